// File: doc/BRIEF.md
# Token-Chain Fall-Through Register FIFO

This block is a first-in first-out buffer made of a chain of data registers, each with its own occupancy flag. There are no read or write pointers and no arbitration. On every clock edge, each occupied stage whose successor is empty hands its word forward, so words ripple from the input end toward the output end. The producer may write only while the first stage is empty. The consumer sees a word whenever the last stage is occupied.

All stage moves are computed from the flags as they stand before the edge and take effect together on that edge. A stage that hands its word on therefore cannot take a new one in the same cycle. Gaps between words travel backward one stage per cycle. Both ends use a valid/ready handshake, and a word transfers in any cycle where valid and ready are both high. The stage count and the data width are separate parameters. The stage count must be at least 2.

Top module: `ripple_fifo`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, every stage is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is high exactly when the first stage is empty. A word offered while `in_ready` is low is not stored. Occupancy changes only by accepted words (+1) and taken words (-1).
- R3: `out_valid` is high exactly when the last stage holds a word. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R4: Words leave in the order they were accepted, with their data unchanged.
- R5: A single word accepted in cycle c into an empty FIFO of DEPTH stages makes `out_valid` rise in cycle c+DEPTH, and not before.
- R6: With the consumer stalled, exactly DEPTH words are accepted before `in_ready` goes low.
- R7: In the cycle after a word is accepted, `in_ready` is low. With both ends always willing, an empty FIFO accepts one word every second cycle.
- R8: A take (`out_valid` and `out_ready` high) empties the last stage on that edge. When the stage before it is occupied, `out_valid` is low for exactly one cycle and then high again.
- R9: When a full FIFO gives up one word in cycle p, `in_ready` is low in cycles p+1 to p+DEPTH-1 and high in cycle p+DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | First stage is empty; the offered word is accepted |
| in_data | input | WIDTH | Word offered by the producer |
| out_valid | output | 1 | Last stage holds a word |
| out_ready | input | 1 | Consumer takes the word at the output |
| out_data | output | WIDTH | Word held in the last stage |

## Verification
The embedded assertions check on every cycle these properties: a stalled output stays stable, an accept always blocks the next cycle, a take clears the last stage, each stage either holds its word or copies its upstream word exactly, and total occupancy tracks accepts minus takes. Some behaviours span many cycles or depend on DEPTH, and only the directed scenarios can show them. These are the exact lone-word latency, the capacity under a stalled consumer, the backward travel of a gap to `in_ready`, the half-rate streaming pattern, and end-to-end word order.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DRAIN = 2'd2
  } stage_act_e;

endpackage

// File: rtl/rfifo_move_ctl.sv
module rfifo_move_ctl #(
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0] occ_q,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic [DEPTH-1:0] load,
  output logic [DEPTH-1:0] drain
);

  localparam int LAST = DEPTH - 1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_move
    if (i == 0) begin : g_head
      assign load[i] = ~occ_q[i] & in_valid;
    end else begin : g_body_in
      assign load[i] = ~occ_q[i] & occ_q[i-1];
    end
    if (i == LAST) begin : g_tail
      assign drain[i] = occ_q[i] & out_ready;
    end else begin : g_body_out
      assign drain[i] = occ_q[i] & ~occ_q[i+1];
    end
  end

endmodule

// File: rtl/rfifo_stage.sv
module rfifo_stage
  import ripple_fifo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             drain,
  input  logic [WIDTH-1:0] din,
  output logic             occ_q,
  output logic [WIDTH-1:0] data_q
);

  stage_act_e act;
  logic       occ_d;

  always_comb begin
    if (load) begin
      act = ACT_LOAD;
    end else if (drain) begin
      act = ACT_DRAIN;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_comb begin
    case (act)
      ACT_LOAD:  occ_d = 1'b1;
      ACT_DRAIN: occ_d = 1'b0;
      default:   occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 1'b0;
    end else begin
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (act == ACT_LOAD) begin
      data_q <= din;
    end
  end

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q && !drain |=> occ_q && $stable(data_q)) else $error("stage hold"); // R3

  AST_STAGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !occ_q && load |=> occ_q && (data_q == $past(din))) else $error("stage fill"); // R4

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] occ_q;
  logic [DEPTH-1:0] load;
  logic [DEPTH-1:0] drain;
  logic [WIDTH-1:0] data_q [DEPTH];

  initial begin
    if (DEPTH < 2) $error("DEPTH must be at least 2");
  end

  rfifo_move_ctl #(.DEPTH(DEPTH)) u_ctl (
    .occ_q     (occ_q),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .load      (load),
    .drain     (drain)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] din;
    if (i == 0) begin : g_src_in
      assign din = in_data;
    end else begin : g_src_prev
      assign din = data_q[i-1];
    end
    rfifo_stage #(.WIDTH(WIDTH)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load[i]),
      .drain  (drain[i]),
      .din    (din),
      .occ_q  (occ_q[i]),
      .data_q (data_q[i])
    );
  end

  assign in_ready  = ~occ_q[0];
  assign out_valid = occ_q[LAST];
  assign out_data  = data_q[LAST];

  AST_OUT_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)) else $error("stall"); // R3

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready) else $error("accept"); // R7

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid) else $error("take"); // R8

  AST_OCC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(occ_q) == $countones($past(occ_q))
              + int'($past(in_valid && in_ready)) - int'($past(out_valid && out_ready))))
    else $error("occupancy"); // R2

endmodule

// File: tb/ripple_fifo_bench.sv
module ripple_fifo_bench;

  localparam int DEPTH = 4;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [WIDTH-1:0] in_data;
  logic             out_valid;
  logic             out_ready;
  logic [WIDTH-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int n_acc;
  logic [WIDTH-1:0] expq [$];
  logic [WIDTH-1:0] seed = 8'h10;

  always #2.5 clk = ~clk;

  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ripple_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge; drives for the coming edge, moves to next negedge.
  task automatic step(input bit iv, input bit ordy);
    bit fin, fout;
    in_valid  = iv;
    in_data   = seed;
    out_ready = ordy;
    fin  = iv && in_ready;
    fout = ordy && out_valid;
    if (fin) begin
      expq.push_back(seed);
      seed = seed + 8'h13;
      n_acc++;
    end
    if (fout) begin
      if (expq.size() == 0) chk(0, "R2", "unexpected word", int'(out_data), -1);
      else begin
        logic [WIDTH-1:0] e;
        e = expq.pop_front();
        chk(out_data == e, "R4", "output order", int'(out_data), int'(e));
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain_all();
    for (int k = 0; k < 4 * DEPTH + 8; k++) step(0, 1);
    chk(expq.size() == 0, "R4", "words left after drain", expq.size(), 0);
    chk(!out_valid, "R2", "out_valid after drain", out_valid, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 0; out_ready = 0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1", "flags during reset", {out_valid, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_latency();
    step(1, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      chk(out_valid == (k == DEPTH), "R5", "lone word out_valid", out_valid, (k == DEPTH));
      if (k < DEPTH) step(0, 0);
    end
    step(0, 1);
    chk(!out_valid, "R8", "last stage cleared by take", out_valid, 0);
    drain_all();
  endtask

  task automatic t_fill_bubble();
    logic [WIDTH-1:0] held;
    n_acc = 0;
    for (int k = 0; k < 3 * DEPTH; k++) step(1, 0);
    chk(n_acc == DEPTH, "R6", "words accepted when stalled", n_acc, DEPTH);
    chk(!in_ready, "R2", "in_ready when full", in_ready, 0);
    held = out_data;
    step(1, 0);
    step(1, 0);
    chk(n_acc == DEPTH, "R2", "no accept while in_ready low", n_acc, DEPTH);
    chk(out_valid && out_data == held, "R3", "stalled output stable", int'(out_data), int'(held));
    step(0, 1);
    for (int k = 1; k <= DEPTH; k++) begin
      if (k == 1) chk(!out_valid, "R8", "gap after take", out_valid, 0);
      if (k == 2) chk(out_valid, "R8", "refill after gap", out_valid, 1);
      chk(in_ready == (k == DEPTH), "R9", "in_ready return", in_ready, (k == DEPTH));
      if (k < DEPTH) step(0, 0);
    end
    drain_all();
  endtask

  task automatic t_stream();
    n_acc = 0;
    for (int k = 0; k < 20; k++) begin
      bit acc;
      acc = in_ready;
      step(1, 1);
      if (acc) chk(!in_ready, "R7", "in_ready low after accept", in_ready, 0);
    end
    chk(n_acc == 10, "R7", "half-rate accepts", n_acc, 10);
    drain_all();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_fill_bubble();
    t_stream();
    t_fill_bubble();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule